// File: doc/BRIEF.md
# Protection Status Register Bank

This block collects the digital outputs of the supply and protection comparators of a display controller and turns them into a small status word for a serial-bus host. Two of the flags, the picture-tube high-voltage sense and the phase-pin flash sense, are protection inputs. Each must stay asserted for a qualifying time of about 1 µs before it has any effect, so glitches are rejected. The other flags go through without filtering.

Each status bit follows its own rule. The overvoltage bit and the 3.3 V reset bit are sticky. A status read clears each of them, but only once its fault has gone away. The vertical-guard, supply-present and core-overvoltage bits are live copies of their inputs.

A one-cycle read strobe, decoded by the bus slave outside this block, captures the whole word into a read register. Any clear that the read causes is applied on the following cycle, and only to the bits that read returned as 1. The block also drives two fault events towards the deflection sequencer: an overvoltage stop, which a disable input can mask, and a flash stop.

Top module: `fault_stat_top`

## Requirements
- R1: While reset is low, and on the first cycle after it, `rd_data_o` is 0 and both `ovp_stop_o` and `flash_stop_o` are 0. The 3.3 V reset bit starts at 1.
- R2: A protection input is qualified only after QUAL_CYC consecutive cycles high (CLK_KHZ*QUAL_NS/1e6, default 250). Any single low cycle restarts the count, and the qualified flag drops on the first edge that samples the input low.
- R3: The overvoltage bit (status bit 1) is set on the clock edge after the high-voltage input becomes qualified. It stays 1 until a read clears it.
- R4: A read clears the overvoltage bit only if, on the cycle after the strobe, the high-voltage input is no longer qualified. Otherwise the bit stays 1.
- R5: `ovp_stop_o` is the overvoltage bit ANDed with NOT `ovp_dis_i`. The disable input changes only the event and never the stored bit.
- R6: The 3.3 V reset bit (status bit 0) is set on the edge that samples `vdd33_low_i` high, and it stays 1 until a read clears it.
- R7: A read clears the 3.3 V reset bit only if `vdd33_low_i` is low on the cycle after the strobe.
- R8: Status bit 2 is a live copy of `vguard_miss_i`. It is not latched.
- R9: Status bit 3 is 1 only when every bit of `sup_ok_i` is 1.
- R10: Status bit 4 is a live copy of `core_hi_i`.
- R11: `flash_stop_o` is high exactly while the flash input is qualified, using the same rule as R2.
- R12: On an edge with `rd_strobe_i` high, `rd_data_o` loads {bit4 core-over, bit3 supply-ok, bit2 guard-miss, bit1 overvoltage, bit0 3.3 V reset}, and it holds that value otherwise. A sticky bit that the captured word showed as 0 is never cleared by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_ok_i | input | N_SUP | Per-rail supply-present comparator flags |
| vdd33_low_i | input | 1 | 3.3 V rail below its reset threshold |
| core_hi_i | input | 1 | Core supply above its overvoltage threshold |
| eht_hi_i | input | 1 | High-voltage sense above its trip level |
| flash_hi_i | input | 1 | Phase-pin flash sense above its trip level |
| vguard_miss_i | input | 1 | Vertical guard pulse missing |
| ovp_dis_i | input | 1 | Masks the overvoltage stop event |
| rd_strobe_i | input | 1 | One-cycle status-read pulse |
| rd_data_o | output | 5 | Status word captured at the last read |
| ovp_stop_o | output | 1 | Overvoltage stop request to the sequencer |
| flash_stop_o | output | 1 | Flash stop request to the sequencer |

## Verification
The inputs feed different paths, so each result is due at a different time.
- The read word is due one edge after the strobe.
- A sticky clear takes effect on the second edge after the strobe.
- A protection event rises after QUAL_CYC sampled high cycles, and the overvoltage bit follows one edge later.
- The disable mask reaches `ovp_stop_o` without any register.

The bench drives inputs only on falling edges and compares outputs on the next falling edge. It compares against a cycle model built from these rules, and directed sequences place the strobe on exactly the edge where a new fault is stored.

// File: rtl/fault_stat_pkg.sv
// Package: shared status-word layout for the protection status bank.
// Assumes the bus slave reads the five bits in the order declared below.
package fault_stat_pkg;
    localparam int STAT_W = 5;
    localparam int IDX_POR = 0;
    localparam int IDX_XPR = 1;

    // Status word, MSB first: core-over, supply-ok, guard-miss, overvoltage, 3.3 V reset.
    typedef struct packed {
        logic core_hi;
        logic sup_ok;
        logic guard_miss;
        logic ovp;
        logic por;
    } fault_stat_t;
endpackage

// File: rtl/persist_qual.sv
// Module: persistence qualifier. Output goes high once the input has been
// sampled high on CYC consecutive edges, and falls on the first low sample.
// Assumes the input is already synchronous to clk.
module persist_qual #(
    parameter int CYC = 250,
    localparam int CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic qual_o
);
    logic [CW-1:0] cnt_q;

    // Count consecutive high samples, saturating at CYC, restarting on any low.
    always_ff @(posedge clk) begin
        if (!rst_n || !raw_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(CYC)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Qualified once the count has reached its terminal value.
    always_comb qual_o = (cnt_q == CW'(CYC));
endmodule

// File: rtl/sticky_bit.sv
// Module: sticky status bit. Set wins over clear; it is cleared only by an
// explicit clear request while the set condition is absent.
// Assumes clr_i is already gated by the caller's read-clear rules.
module sticky_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold the flag, with set taking priority over the read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= RST_VAL;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end
endmodule

// File: rtl/fault_stat_top.sv
// Module: protection status register bank. Qualifies the high-voltage and
// flash inputs, keeps the sticky overvoltage and 3.3 V reset bits, captures
// the status word on a read strobe and applies the read clear one cycle later.
// Assumes all comparator flags are synchronous to clk.
module fault_stat_top
    import fault_stat_pkg::*;
#(
    parameter int N_SUP = 5,
    parameter int CLK_KHZ = 250000,
    parameter int QUAL_NS = 1000,
    localparam int QUAL_CYC = (CLK_KHZ * QUAL_NS) / 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SUP-1:0]  sup_ok_i,
    input  logic              vdd33_low_i,
    input  logic              core_hi_i,
    input  logic              eht_hi_i,
    input  logic              flash_hi_i,
    input  logic              vguard_miss_i,
    input  logic              ovp_dis_i,
    input  logic              rd_strobe_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              ovp_stop_o,
    output logic              flash_stop_o
);
    logic [1:0]  raw_w;
    logic [1:0]  qual_w;
    logic [1:0]  set_w;
    logic [1:0]  sticky_w;
    logic        rd_pend_q;
    fault_stat_t live_w;

    // Route the protection inputs into the qualifiers: 0 = high voltage, 1 = flash.
    always_comb raw_w = {flash_hi_i, eht_hi_i};

    for (genvar g = 0; g < 2; g++) begin : g_qual
        persist_qual #(.CYC(QUAL_CYC)) u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_w[g]),
            .qual_o (qual_w[g])
        );
    end

    // Set sources of the sticky bits, indexed by their status bit position.
    always_comb begin
        set_w[IDX_POR] = vdd33_low_i;
        set_w[IDX_XPR] = qual_w[0];
    end

    for (genvar g = 0; g < 2; g++) begin : g_sticky
        sticky_bit #(.RST_VAL(g == IDX_POR)) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_w[g]),
            .clr_i (rd_pend_q & rd_data_o[g]),
            .q_o   (sticky_w[g])
        );
    end

    // Assemble the live status word from the sticky bits and the pass-through flags.
    always_comb begin
        live_w.core_hi    = core_hi_i;
        live_w.sup_ok     = &sup_ok_i;
        live_w.guard_miss = vguard_miss_i;
        live_w.ovp        = sticky_w[IDX_XPR];
        live_w.por        = sticky_w[IDX_POR];
    end

    // Capture the word on a strobe and remember that a clear is due next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
            rd_pend_q <= 1'b0;
        end else begin
            rd_pend_q <= rd_strobe_i;
            if (rd_strobe_i) begin
                rd_data_o <= live_w;
            end
        end
    end

    // Fault events to the deflection sequencer.
    always_comb begin
        ovp_stop_o   = sticky_w[IDX_XPR] & ~ovp_dis_i;
        flash_stop_o = qual_w[1];
    end
endmodule

// File: rtl/fault_stat_chk.sv
// Module: assertion checker for fault_stat_top, bound to every instance.
// Assumes the internal names connected in the bind statement below.
module fault_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flash_hi_i,
    input logic       vdd33_low_i,
    input logic       vguard_miss_i,
    input logic       ovp_dis_i,
    input logic       rd_strobe_i,
    input logic [4:0] rd_data_o,
    input logic       ovp_stop_o,
    input logic       flash_stop_o,
    input logic       eht_qual,
    input logic       xpr_q,
    input logic       por_q,
    input logic       rd_pend_q
);
    p_flash_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_hi_i |=> !flash_stop_o);
    p_xpr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xpr_q && !rd_pend_q |=> xpr_q);
    p_xpr_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend_q && eht_qual |=> xpr_q);
    p_ovp_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_dis_i |-> !ovp_stop_o);
    p_por_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vdd33_low_i |=> por_q);
    p_guard_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe_i |=> rd_data_o[2] == $past(vguard_miss_i));
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_i |=> $stable(rd_data_o));
endmodule

bind fault_stat_top fault_stat_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flash_hi_i    (flash_hi_i),
    .vdd33_low_i   (vdd33_low_i),
    .vguard_miss_i (vguard_miss_i),
    .ovp_dis_i     (ovp_dis_i),
    .rd_strobe_i   (rd_strobe_i),
    .rd_data_o     (rd_data_o),
    .ovp_stop_o    (ovp_stop_o),
    .flash_stop_o  (flash_stop_o),
    .eht_qual      (qual_w[0]),
    .xpr_q         (sticky_w[1]),
    .por_q         (sticky_w[0]),
    .rd_pend_q     (rd_pend_q)
);

// File: tb/fault_stat_top_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random stimulus, compared each
// cycle against a model built from the requirements.
module fault_stat_top_test;
    localparam int NS = 5;
    localparam int Q = (250000 * 1000) / 1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] sup_ok = '1;
    logic vlow = 1'b0, core = 1'b0, eht = 1'b0, fl = 1'b0, vg = 1'b0, xdt = 1'b0, rd = 1'b0;
    logic [4:0] rd_data;
    logic ovp_stop, flash_stop;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Model state.
    int m_ecnt, m_fcnt;
    logic m_xpr, m_por, m_pend;
    logic [4:0] m_rd;

    fault_stat_top uut (
        .clk(clk), .rst_n(rst_n), .sup_ok_i(sup_ok), .vdd33_low_i(vlow),
        .core_hi_i(core), .eht_hi_i(eht), .flash_hi_i(fl), .vguard_miss_i(vg),
        .ovp_dis_i(xdt), .rd_strobe_i(rd), .rd_data_o(rd_data),
        .ovp_stop_o(ovp_stop), .flash_stop_o(flash_stop)
    );

    always #2 clk = ~clk;

    function automatic int next_run(int run, logic in);
        if (!in) return 0;
        return (run >= Q) ? Q : run + 1;
    endfunction

    // Cycle model: applies the requirement rules on each rising edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_ecnt <= 0; m_fcnt <= 0; m_xpr <= 1'b0; m_por <= 1'b1;
            m_pend <= 1'b0; m_rd <= '0;
        end else begin
            m_ecnt <= next_run(m_ecnt, eht);
            m_fcnt <= next_run(m_fcnt, fl);
            m_xpr  <= (m_ecnt == Q) | (m_xpr & ~(m_pend & m_rd[1]));
            m_por  <= vlow | (m_por & ~(m_pend & m_rd[0]));
            m_pend <= rd;
            if (rd) m_rd <= {core, &sup_ok, vg, m_xpr, m_por};
        end
    end

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Compare every output against the model, one tag per bit.
    task automatic compare_all();
        check("R6/R7 por bit", {4'b0, rd_data[0]}, {4'b0, m_rd[0]});
        check("R3/R4 ovp bit", {4'b0, rd_data[1]}, {4'b0, m_rd[1]});
        check("R8 guard bit", {4'b0, rd_data[2]}, {4'b0, m_rd[2]});
        check("R9 supply bit", {4'b0, rd_data[3]}, {4'b0, m_rd[3]});
        check("R10 core bit", {4'b0, rd_data[4]}, {4'b0, m_rd[4]});
        check("R5 ovp event", {4'b0, ovp_stop}, {4'b0, m_xpr & ~xdt});
        check("R11 flash event", {4'b0, flash_stop}, {4'b0, 1'(m_fcnt == Q)});
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic do_read();
        rd = 1'b1; tick(); rd = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        tick(3);
        check("R1 reset word", rd_data, 5'b0);
        check("R1 reset events", {3'b0, ovp_stop, flash_stop}, 5'b0);
        rst_n = 1'b1;
        tick();
        check("R1 after reset", {2'b0, rd_data[1:0], flash_stop}, 5'b0);

        // R6/R7: the reset bit starts at 1 and clears once read with the rail good.
        do_read();
        check("R6 por starts set", {4'b0, rd_data[0]}, 5'b1);
        tick();
        do_read();
        check("R7 por cleared", {4'b0, rd_data[0]}, 5'b0);
        vlow = 1'b1; tick(); do_read(); tick();
        do_read();
        check("R7 por kept while low", {4'b0, rd_data[0]}, 5'b1);
        vlow = 1'b0; tick(); do_read(); tick();
        do_read();
        check("R7 por cleared after recovery", {4'b0, rd_data[0]}, 5'b0);

        // R2/R11: a gap of one low cycle restarts the qualification.
        fl = 1'b1; tick(Q - 1);
        check("R2 not yet qualified", {4'b0, flash_stop}, 5'b0);
        fl = 1'b0; tick();
        fl = 1'b1; tick(Q - 1);
        check("R2 restart after gap", {4'b0, flash_stop}, 5'b0);
        tick();
        check("R11 flash qualified", {4'b0, flash_stop}, 5'b1);
        fl = 1'b0; tick();
        check("R11 flash drop", {4'b0, flash_stop}, 5'b0);

        // R3/R4/R5: the overvoltage bit latches and is held while the fault persists.
        eht = 1'b1; tick(Q + 1);
        check("R3 ovp event", {4'b0, ovp_stop}, 5'b1);
        xdt = 1'b1; tick();
        check("R5 masked event", {4'b0, ovp_stop}, 5'b0);
        do_read();
        check("R5 bit kept under mask", {4'b0, rd_data[1]}, 5'b1);
        xdt = 1'b0;
        tick(); eht = 1'b0; tick();
        do_read();
        check("R4 kept while fault present", {4'b0, rd_data[1]}, 5'b1);
        tick();
        do_read();
        check("R4 cleared after fault gone", {4'b0, rd_data[1]}, 5'b0);

        // R12: a fault stored on the capture edge is not cleared by that read.
        eht = 1'b1; tick(Q);
        rd = 1'b1; eht = 1'b0; tick(); rd = 1'b0;
        check("R12 capture saw old bit", {4'b0, rd_data[1]}, 5'b0);
        tick(2);
        do_read();
        check("R12 new fault survives", {4'b0, rd_data[1]}, 5'b1);
        tick(); do_read();

        // Random phase mixing long protection pulses with frequent reads.
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 150 == 0) eht = ~eht;
            if ($urandom % 150 == 0) fl = ~fl;
            if ($urandom % 300 == 0) vlow = ~vlow;
            if ($urandom % 20 == 0) vg = ~vg;
            if ($urandom % 100 == 0) xdt = ~xdt;
            core = ($urandom % 10 == 0);
            sup_ok = ($urandom % 8 == 0) ? NS'($urandom) : '1;
            rd = ($urandom % 12 == 0);
            tick();
        end
        rd = 1'b0;
        done = 1'b1;
        report();
    end
endmodule